// File: doc/BRIEF.md
# Temperature Conversion Mode Sequencer

This block decides when a temperature conversion runs and keeps the most recent result. A two-bit mode field picks one of four schedules: conversions back to back, a single conversion followed by power-down, a short conversion at the start of each fixed period with idle time after it, or powered down. The first conversion after reset is a short "fast" one. Later conversions use the normal length. All durations are counted in ticks from an internal prescaler, so simulation runs are short.

The analog converter sits outside the block. The sequencer pulses `conv_start` and holds `conv_busy` high for the whole conversion window. At the end of the window it raises `conv_ready` and waits for the converter to offer a result on `conv_valid`/`conv_code`. A result is accepted only in a cycle where both `conv_valid` and `conv_ready` are high. If the converter holds `conv_valid` low, the sequencer keeps waiting with `conv_busy` high, so the converter can apply back-pressure for as long as it needs. The accepted code is written into the value register, trimmed or kept whole according to the resolution bit.

A staleness flag tells readers whether the value register holds data they have not yet read. A write of mode and resolution through `cfg_wr` takes effect at once. It aborts any conversion in flight without touching the stored value and restarts the tick prescaler.

Top module: `tconv_sched`

## Requirements
- R1: During and right after reset, the mode is continuous (00) and the resolution bit is 0, `data_stale` is 1, `temp_val` is 0, and a conversion is in progress (`conv_start` high in the first cycle, `conv_busy` high).
- R2: The first conversion after reset lasts T_FAST ticks. Every later conversion in mode 00 or mode 01 lasts T_NORM ticks.
- R3: In mode 00, a new conversion starts in the cycle after each accepted result (`conv_start` high), and each accepted result overwrites `temp_val`.
- R4: Writing mode 01 starts one conversion of T_NORM ticks. After its result is accepted, the block stays powered down (`conv_busy` low, no `conv_start`) until the next write.
- R5: Writing mode 10 starts a conversion of T_SPS ticks. After each accepted result the block idles for T_PERIOD−T_SPS ticks and then starts the next conversion of T_SPS ticks.
- R6: Writing mode 11 stops all conversion activity. `temp_val` keeps its last value and `conv_busy` stays low.
- R7: Writing mode 00 while powered down (after mode 11 or after a completed one-shot) waits T_WAKE ticks and then starts a T_NORM conversion. Writing 00 at any other time restarts a T_NORM conversion at once.
- R8: Any `cfg_wr` aborts the conversion in progress. No result is accepted in that cycle, `temp_val` is unchanged, and the tick prescaler restarts from zero.
- R9: `data_stale` goes to 0 in the cycle after a result is accepted. It goes to 1 after a `val_rd` pulse, and also after a `cfg_wr` that writes mode 01 or mode 10. If a result is accepted in the same cycle as a read, the result wins.
- R10: With the resolution bit at 0, an accepted code is stored as code[15:3] in bits 15:3 with bits 2:0 cleared. With the bit at 1, all 16 bits are stored unchanged.
- R11: `conv_ready` is high only at the end of a conversion window. A result is accepted only when `conv_valid` and `conv_ready` are both high, and while `conv_valid` is low the block waits with `conv_busy` high.
- R12: `conv_busy` is high from the `conv_start` cycle through the cycle in which the result is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the mode and resolution fields |
| cfg_mode | input | 2 | Mode: 00 continuous, 01 one-shot, 10 periodic, 11 off |
| cfg_res | input | 1 | Resolution: 0 = 13-bit, 1 = 16-bit |
| val_rd | input | 1 | Pulse marking a read of the value register |
| conv_start | output | 1 | One-cycle pulse when a conversion begins |
| conv_busy | output | 1 | High throughout an active conversion |
| conv_ready | output | 1 | Sequencer will accept a result this cycle |
| conv_valid | input | 1 | Converter offers a result |
| conv_code | input | 16 | Converter result, two's complement, 1/128 degree per LSB |
| temp_val | output | 16 | Stored temperature value |
| data_stale | output | 1 | 1 when the stored value has been read or no result has arrived yet |

## Verification
A wrong count or a wrong state in the sequencer shows on `conv_busy`, `conv_start` or `conv_ready` in the first cycle where a window ends early or late. A mishandled abort shows up as a changed `temp_val` or `data_stale`. Because the bench model is compared against every port on every clock, a fault is reported at the clock where it first diverges, not at the end of a scenario. Faults in resolution trimming or capture priority appear on `temp_val` and `data_stale` in the cycle right after the accept.

// File: rtl/tconv_pkg.sv
package tconv_pkg;
  typedef enum logic [1:0] {
    MODE_CONT = 2'b00,
    MODE_ONCE = 2'b01,
    MODE_SPS  = 2'b10,
    MODE_OFF  = 2'b11
  } tmode_e;

  typedef enum logic [2:0] {
    ST_CONV = 3'd0,
    ST_DONE = 3'd1,
    ST_IDLE = 3'd2,
    ST_WAKE = 3'd3,
    ST_OFF  = 3'd4
  } tstate_e;
endpackage

// File: rtl/tconv_tick.sv
module tconv_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pc;

  always_ff @(posedge clk) begin
    if (!rst_n)               pc <= '0;
    else if (restart || tick) pc <= '0;
    else                      pc <= pc + 1'b1;
  end

  assign tick = (pc == LAST);

  generate
    if (DIV > 1) begin : g_chk
      // R8: the timebase restarts on a configuration write
      assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/tconv_fsm.sv
module tconv_fsm
  import tconv_pkg::*;
#(
  parameter int T_FAST   = 2,
  parameter int T_NORM   = 8,
  parameter int T_SPS    = 3,
  parameter int T_PERIOD = 10,
  parameter int T_WAKE   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_mode,
  input  logic       conv_valid,
  output logic       conv_start,
  output logic       conv_busy,
  output logic       conv_ready,
  output logic       cap
);
  localparam int T_IDLE = T_PERIOD - T_SPS;
  localparam int TM1 = (T_NORM > T_FAST) ? T_NORM : T_FAST;
  localparam int TM2 = (TM1 > T_PERIOD) ? TM1 : T_PERIOD;
  localparam int TMAX = (TM2 > T_WAKE) ? TM2 : T_WAKE;
  localparam int CW = $clog2(TMAX + 1);

  tstate_e       state;
  tmode_e        mode_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] len;
  logic [CW-1:0] lim;
  logic          start_q;
  logic          last;

  always_comb begin
    case (state)
      ST_IDLE: lim = CW'(T_IDLE);
      ST_WAKE: lim = CW'(T_WAKE);
      default: lim = len;
    endcase
  end

  assign last = tick && (cnt == lim - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_CONV;
      mode_q  <= MODE_CONT;
      cnt     <= '0;
      len     <= CW'(T_FAST);
      start_q <= 1'b1;
    end else begin
      start_q <= 1'b0;
      if (cfg_wr) begin
        mode_q <= tmode_e'(cfg_mode);
        cnt    <= '0;
        case (tmode_e'(cfg_mode))
          MODE_CONT: begin
            if (state == ST_OFF) state <= ST_WAKE;
            else begin
              state   <= ST_CONV;
              len     <= CW'(T_NORM);
              start_q <= 1'b1;
            end
          end
          MODE_ONCE: begin
            state   <= ST_CONV;
            len     <= CW'(T_NORM);
            start_q <= 1'b1;
          end
          MODE_SPS: begin
            state   <= ST_CONV;
            len     <= CW'(T_SPS);
            start_q <= 1'b1;
          end
          default: state <= ST_OFF;
        endcase
      end else begin
        case (state)
          ST_CONV: begin
            if (last) begin
              state <= ST_DONE;
              cnt   <= '0;
            end else if (tick) cnt <= cnt + 1'b1;
          end
          ST_DONE: begin
            if (conv_valid) begin
              cnt <= '0;
              case (mode_q)
                MODE_CONT: begin
                  state   <= ST_CONV;
                  len     <= CW'(T_NORM);
                  start_q <= 1'b1;
                end
                MODE_SPS: state <= ST_IDLE;
                default:  state <= ST_OFF;
              endcase
            end
          end
          ST_IDLE: begin
            if (last) begin
              state   <= ST_CONV;
              len     <= CW'(T_SPS);
              start_q <= 1'b1;
              cnt     <= '0;
            end else if (tick) cnt <= cnt + 1'b1;
          end
          ST_WAKE: begin
            if (last) begin
              state   <= ST_CONV;
              len     <= CW'(T_NORM);
              start_q <= 1'b1;
              cnt     <= '0;
            end else if (tick) cnt <= cnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign conv_start = start_q;
  assign conv_busy  = (state == ST_CONV) || (state == ST_DONE);
  assign conv_ready = (state == ST_DONE);
  assign cap        = conv_ready && conv_valid && !cfg_wr;

  assert_start_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> conv_busy);
  assert_ready_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_ready |-> conv_busy);
  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !conv_ready);
  assert_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_OFF) |-> !conv_busy);
endmodule

// File: rtl/tconv_result.sv
module tconv_result #(
  parameter int DW = 16,
  parameter int TRIM = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_res,
  input  logic          clr_stale,
  input  logic          val_rd,
  input  logic          cap,
  input  logic [DW-1:0] code,
  output logic [DW-1:0] temp_val,
  output logic          data_stale
);
  logic res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q      <= 1'b0;
      temp_val   <= '0;
      data_stale <= 1'b1;
    end else begin
      if (cfg_wr) res_q <= cfg_res;
      if (cap) begin
        temp_val   <= res_q ? code : {code[DW-1:TRIM], TRIM'(0)};
        data_stale <= 1'b0;
      end else if (val_rd || clr_stale) begin
        data_stale <= 1'b1;
      end
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(temp_val));
  assert_fresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> !data_stale);
  assert_trim_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !res_q) |=> (temp_val[TRIM-1:0] == '0));
endmodule

// File: rtl/tconv_sched.sv
module tconv_sched
  import tconv_pkg::*;
#(
  parameter int DIV      = 4,
  parameter int T_FAST   = 2,
  parameter int T_NORM   = 8,
  parameter int T_SPS    = 3,
  parameter int T_PERIOD = 10,
  parameter int T_WAKE   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [1:0]  cfg_mode,
  input  logic        cfg_res,
  input  logic        val_rd,
  output logic        conv_start,
  output logic        conv_busy,
  output logic        conv_ready,
  input  logic        conv_valid,
  input  logic [15:0] conv_code,
  output logic [15:0] temp_val,
  output logic        data_stale
);
  logic tick;
  logic cap;
  logic clr_stale;

  assign clr_stale = cfg_wr && ((tmode_e'(cfg_mode) == MODE_ONCE) ||
                                (tmode_e'(cfg_mode) == MODE_SPS));

  tconv_tick #(.DIV(DIV)) tick_i (
    .clk(clk), .rst_n(rst_n), .restart(cfg_wr), .tick(tick)
  );

  tconv_fsm #(
    .T_FAST(T_FAST), .T_NORM(T_NORM), .T_SPS(T_SPS),
    .T_PERIOD(T_PERIOD), .T_WAKE(T_WAKE)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_wr(cfg_wr),
    .cfg_mode(cfg_mode), .conv_valid(conv_valid), .conv_start(conv_start),
    .conv_busy(conv_busy), .conv_ready(conv_ready), .cap(cap)
  );

  tconv_result #(.DW(16), .TRIM(3)) res_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_res(cfg_res),
    .clr_stale(clr_stale), .val_rd(val_rd), .cap(cap), .code(conv_code),
    .temp_val(temp_val), .data_stale(data_stale)
  );

  // R11: a result is only taken while the sequencer is ready
  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_ready) |=> $stable(temp_val));
endmodule

// File: tb/tconv_sched_tb.sv
module tconv_sched_tb_top;
  localparam int DIV = 2, TF = 2, TN = 5, TS = 2, TP = 6, TW = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_mode = 2'b00;
  logic        cfg_res = 1'b0;
  logic        val_rd = 1'b0;
  logic        conv_valid = 1'b1;
  logic [15:0] conv_code = 16'h0a5f;
  logic        conv_start, conv_busy, conv_ready, data_stale;
  logic [15:0] temp_val;

  int vecs = 0, bad = 0, cyc = 0;
  bit run_cmp = 1'b0;

  // reference model state: st 0 conv, 1 done, 2 idle, 3 wake, 4 off
  int m_pc, m_st, m_cnt, m_len, m_mode;
  bit m_res, m_start, m_stale, m_first;
  logic [15:0] m_val;

  always #5 clk = ~clk;

  tconv_sched #(.DIV(DIV), .T_FAST(TF), .T_NORM(TN), .T_SPS(TS),
                .T_PERIOD(TP), .T_WAKE(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .cfg_res(cfg_res), .val_rd(val_rd), .conv_start(conv_start),
    .conv_busy(conv_busy), .conv_ready(conv_ready), .conv_valid(conv_valid),
    .conv_code(conv_code), .temp_val(temp_val), .data_stale(data_stale)
  );

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic string mtag();
    if (m_st == 3) return "R7";
    if (m_first) return "R2";
    case (m_mode)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_pc = 0; m_st = 0; m_cnt = 0; m_len = TF; m_mode = 0;
      m_res = 0; m_start = 1; m_stale = 1; m_val = 16'h0; m_first = 1;
    end else begin
      bit tk;
      int lim;
      tk = (m_pc == DIV - 1);
      m_pc = (cfg_wr || tk) ? 0 : m_pc + 1;
      if (m_st == 1 && conv_valid && !cfg_wr) begin
        m_val = m_res ? conv_code : (conv_code & 16'hfff8);
        m_stale = 0;
      end else if (val_rd || (cfg_wr && (cfg_mode == 2'd1 || cfg_mode == 2'd2)))
        m_stale = 1;
      if (cfg_wr) m_res = cfg_res;
      m_start = 0;
      lim = (m_st == 2) ? TP - TS : (m_st == 3) ? TW : m_len;
      if (cfg_wr) begin
        m_first = 0;
        m_mode = cfg_mode;
        m_cnt = 0;
        if (cfg_mode == 2'd3) m_st = 4;
        else if (cfg_mode == 2'd0 && m_st == 4) m_st = 3;
        else begin
          m_st = 0; m_start = 1;
          m_len = (cfg_mode == 2'd2) ? TS : TN;
        end
      end else if (m_st == 1) begin
        if (conv_valid) begin
          m_first = 0;
          m_cnt = 0;
          if (m_mode == 0) begin m_st = 0; m_len = TN; m_start = 1; end
          else if (m_mode == 2) m_st = 2;
          else m_st = 4;
        end
      end else if (m_st != 4 && tk) begin
        if (m_cnt == lim - 1) begin
          m_cnt = 0;
          if (m_st == 0) m_st = 1;
          else begin
            m_st = 0; m_start = 1;
            m_len = (m_st == 2) ? TS : TN;
            m_len = (m_mode == 2) ? TS : TN;
          end
        end else m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (run_cmp) begin
      chk({"R12/", mtag()}, "busy", 16'(conv_busy), 16'(m_st == 0 || m_st == 1));
      chk(mtag(), "start", 16'(conv_start), 16'(m_start));
      chk("R11", "ready", 16'(conv_ready), 16'(m_st == 1));
      chk("R10", "temp_val", temp_val, m_val);
      chk("R9", "stale", 16'(data_stale), 16'(m_stale));
    end
    conv_code <= conv_code + 16'h0137;
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] m, logic r);
    cfg_mode = m; cfg_res = r; cfg_wr = 1'b1;
    step(1);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_every(int n, int gap);
    for (int i = 0; i < n; i++) begin
      val_rd = ((i % gap) == 0);
      step(1);
    end
    val_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  initial begin
    logic [15:0] keep;
    step(2);
    // R1: reset values
    chk("R1", "stale", 16'(data_stale), 16'd1);
    chk("R1", "temp_val", temp_val, 16'h0);
    chk("R1", "busy", 16'(conv_busy), 16'd1);
    chk("R1", "start", 16'(conv_start), 16'd1);
    rst_n = 1'b1;
    run_cmp = 1'b1;
    rd_every(40, 7);
    // R8: abort to shutdown mid-conversion, value held
    while (!(conv_busy && !conv_ready)) step(1);
    keep = temp_val;
    wr(2'b11, 1'b0);
    chk("R8", "busy after abort", 16'(conv_busy), 16'd0);
    chk("R8", "temp_val after abort", temp_val, keep);
    step(15);
    chk("R6", "temp_val held off", temp_val, keep);
    rd_every(5, 2);
    wr(2'b00, 1'b1);          // R7 wake
    rd_every(40, 5);
    wr(2'b01, 1'b0);          // R4 one-shot
    rd_every(30, 9);
    wr(2'b10, 1'b1);          // R5 periodic
    rd_every(60, 6);
    wr(2'b00, 1'b0);          // R7 restart without wake
    rd_every(20, 4);
    conv_valid = 1'b0;        // R11 back-pressure
    step(25);
    conv_valid = 1'b1;
    rd_every(20, 3);
    conv_valid = 1'b0;
    while (!conv_ready) step(1);
    wr(2'b10, 1'b0);          // R8 abort while waiting
    conv_valid = 1'b1;
    rd_every(30, 1);          // R9 read every cycle races captures
    wr(2'b01, 1'b1);
    step(20);
    wr(2'b00, 1'b1);          // R7 wake from finished one-shot
    rd_every(30, 8);
    finish_run();
  end

  initial begin
    wait (cyc > 20000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=<20000", cyc);
    finish_run();
  end
endmodule